// File: doc/BRIEF.md
# Transmit Power Ramp Controller

This block shapes the rise and fall of a power amplifier's drive level. It keeps one ramp profile table and one target power value per output channel, both written by the processor ahead of time. When an external sequencer pulses the trigger, the block walks the table and emits one DAC code per channel at a programmed spacing. Each code is the table entry multiplied by that channel's target and shifted right by the table width. The sequencer's direction input picks a rising ramp, which reads the table forward, or a falling ramp, which reads it backward.

Three channels share one ramp sequencer. Enable bits choose which channels follow the ramp. A disabled channel sits at code zero. Two overrides are available. Bypass places each enabled channel's static target on its DAC. Stream mode passes live I and Q samples onto the first two channels. Neither override disturbs the ramp in progress, so the ramp output reappears once the override is released.

Top module: `tx_ramp_ctrl`

## Requirements
- R1: After reset, every DAC code is 0 and both `busy` and `done` are low.
- R2: A trigger with `ramp_dir`=1 sampled at clock edge k while idle produces, on each enabled channel c, the codes (P[c][i]*T[c])>>10 for i = 0..N-1, where N = `len_cfg`+1. Code i is visible from the edge k+i*S+1 onward. P is the 10-bit profile entry and T the 12-bit target.
- R3: The spacing S in clocks between samples is `step_cfg`, captured at the trigger. A value of 0 acts as 1.
- R4: A trigger with `ramp_dir`=0 reads the profile in reverse, so sample i uses entry N-1-i.
- R5: `busy` is high from edge k up to edge k+N*S. `done` is high for exactly the one cycle after edge k+N*S. Afterwards the outputs hold the last sample.
- R6: A trigger that arrives while `busy` is high is ignored, including its direction. The sample sequence and the `done` timing are unchanged.
- R7: A channel whose `ch_en` bit is 0 outputs code 0 one clock later, unless stream mode overrides it.
- R8: With `bypass`=1, each enabled channel outputs its target code one clock later.
- R9: With `iq_mode`=1, channel 0 outputs `iq_i` and channel 1 outputs `iq_q` one clock later, whatever the enables and bypass say. Channel 2 keeps its normal behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lut_we | input | 1 | Profile table write strobe |
| lut_ch | input | 2 | Channel whose table is written |
| lut_addr | input | 4 | Table entry index |
| lut_data | input | 10 | Profile entry value |
| tgt_we | input | 1 | Target write strobe |
| tgt_ch | input | 2 | Channel whose target is written |
| tgt_data | input | 12 | Target power code |
| step_cfg | input | 8 | Clocks between samples |
| len_cfg | input | 4 | Sample count minus one |
| ch_en | input | 3 | Per-channel ramp enable |
| ramp_dir | input | 1 | 1 rising, 0 falling |
| ramp_trig | input | 1 | Start pulse from sequencer |
| bypass | input | 1 | Apply static target |
| iq_mode | input | 1 | Stream I/Q to channels 0 and 1 |
| iq_i | input | 12 | In-phase sample |
| iq_q | input | 12 | Quadrature sample |
| dac_code | output | 36 | Channel c code at bits [12c+11:12c] |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle end-of-ramp pulse |

## Verification
Some internal faults show up as wrong codes at the DAC within one sample spacing of the trigger: a bad index or remaining-count register, or a wrong direction latch. Examples are a repeated entry, a skipped entry or a mirrored sequence. A spacing counter that is off by one moves each later code by one clock per sample and shifts the `done` pulse by N clocks. The bench therefore compares every clock of every ramp rather than only the endpoints. A sequencer that re-arms on a trigger while busy restarts the sequence, which shows at the next sample edge.

// File: rtl/tprc_pkg.sv
package tprc_pkg;

    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } ramp_dir_e;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_RAMP,
        SRC_TARGET,
        SRC_STREAM
    } out_src_e;

endpackage

// File: rtl/tprc_lut.sv
module tprc_lut #(
    parameter int N_CH  = 3,
    parameter int LUT_W = 10,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CH_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [CH_W-1:0]         wch,
    input  logic [AW-1:0]           waddr,
    input  logic [LUT_W-1:0]        wdata,
    input  logic [AW-1:0]           raddr,
    output logic [N_CH*LUT_W-1:0]   rdata
);

    for (genvar c = 0; c < N_CH; c++) begin : g_tab
        logic [LUT_W-1:0] mem_q [DEPTH];
        logic [LUT_W-1:0] mem_d [DEPTH];

        always_comb begin
            mem_d = mem_q;
            if (we && (wch == CH_W'(c))) begin
                mem_d[waddr] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
                mem_q <= mem_d;
            end
        end

        assign rdata[c*LUT_W +: LUT_W] = mem_q[raddr];
    end

endmodule

// File: rtl/tprc_seq.sv
module tprc_seq
    import tprc_pkg::*;
#(
    parameter int AW     = 4,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              dir,
    input  logic [STEP_W-1:0] step_cfg,
    input  logic [AW-1:0]     len_cfg,
    output logic              busy,
    output logic              done,
    output logic              load,
    output logic [AW-1:0]     addr
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              rise;
        logic [AW-1:0]     idx;
        logic [AW-1:0]     left;
        logic [STEP_W-1:0] cnt;
        logic [STEP_W-1:0] gap;
    } seq_t;

    seq_t s_q, s_d;
    logic [STEP_W-1:0] gap_new;

    always_comb begin
        gap_new = (step_cfg == '0) ? '0 : step_cfg - STEP_W'(1);
        s_d      = s_q;
        s_d.done = 1'b0;
        load     = 1'b0;
        addr     = s_q.idx;
        if (!s_q.busy) begin
            if (trig) begin
                s_d.busy = 1'b1;
                s_d.rise = (ramp_dir_e'(dir) == DIR_RISE);
                s_d.idx  = s_d.rise ? '0 : len_cfg;
                s_d.left = len_cfg;
                s_d.gap  = gap_new;
                s_d.cnt  = gap_new;
                load     = 1'b1;
                addr     = s_d.idx;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - STEP_W'(1);
        end else if (s_q.left != '0) begin
            s_d.idx  = s_q.rise ? s_q.idx + AW'(1) : s_q.idx - AW'(1);
            s_d.left = s_q.left - AW'(1);
            s_d.cnt  = s_q.gap;
            load     = 1'b1;
            addr     = s_d.idx;
        end else begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;

endmodule

// File: rtl/tprc_chan.sv
module tprc_chan
    import tprc_pkg::*;
#(
    parameter int  LUT_W  = 10,
    parameter int  DAC_W  = 12,
    parameter bit  HAS_IQ = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_we,
    input  logic [DAC_W-1:0] tgt_data,
    input  logic             load,
    input  logic [LUT_W-1:0] lut_word,
    input  logic             en,
    input  logic             bypass,
    input  logic             iq_mode,
    input  logic [DAC_W-1:0] iq_data,
    output logic [DAC_W-1:0] dac,
    output logic [DAC_W-1:0] tgt
);

    localparam int PW = LUT_W + DAC_W;

    typedef struct packed {
        logic [DAC_W-1:0] tgt;
        logic [DAC_W-1:0] ramp;
        logic [DAC_W-1:0] out;
    } ch_t;

    ch_t      c_q, c_d;
    logic [PW-1:0] prod;
    out_src_e src;

    always_comb begin
        prod = PW'(lut_word) * PW'(c_q.tgt);
        if (HAS_IQ && iq_mode) src = SRC_STREAM;
        else if (!en)          src = SRC_ZERO;
        else if (bypass)       src = SRC_TARGET;
        else                   src = SRC_RAMP;

        c_d = c_q;
        if (tgt_we) c_d.tgt  = tgt_data;
        if (load)   c_d.ramp = prod[LUT_W +: DAC_W];
        case (src)
            SRC_STREAM: c_d.out = iq_data;
            SRC_TARGET: c_d.out = c_q.tgt;
            SRC_RAMP:   c_d.out = c_q.ramp;
            default:    c_d.out = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign dac = c_q.out;
    assign tgt = c_q.tgt;

endmodule

// File: rtl/tx_ramp_ctrl.sv
module tx_ramp_ctrl #(
    parameter int N_CH   = 3,
    parameter int LUT_W  = 10,
    parameter int DAC_W  = 12,
    parameter int DEPTH  = 16,
    parameter int STEP_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lut_we,
    input  logic [1:0]             lut_ch,
    input  logic [$clog2(DEPTH)-1:0] lut_addr,
    input  logic [LUT_W-1:0]       lut_data,
    input  logic                   tgt_we,
    input  logic [1:0]             tgt_ch,
    input  logic [DAC_W-1:0]       tgt_data,
    input  logic [STEP_W-1:0]      step_cfg,
    input  logic [$clog2(DEPTH)-1:0] len_cfg,
    input  logic [N_CH-1:0]        ch_en,
    input  logic                   ramp_dir,
    input  logic                   ramp_trig,
    input  logic                   bypass,
    input  logic                   iq_mode,
    input  logic [DAC_W-1:0]       iq_i,
    input  logic [DAC_W-1:0]       iq_q,
    output logic [N_CH*DAC_W-1:0]  dac_code,
    output logic                   busy,
    output logic                   done
);

    localparam int AW   = $clog2(DEPTH);
    localparam int CH_W = 2;

    logic                   load;
    logic [AW-1:0]          addr;
    logic [N_CH*LUT_W-1:0]  lut_rd;
    logic [N_CH*DAC_W-1:0]  tgt_vec;

    tprc_lut #(
        .N_CH(N_CH), .LUT_W(LUT_W), .DEPTH(DEPTH), .AW(AW), .CH_W(CH_W)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .we(lut_we), .wch(lut_ch),
        .waddr(lut_addr), .wdata(lut_data), .raddr(addr), .rdata(lut_rd)
    );

    tprc_seq #(
        .AW(AW), .STEP_W(STEP_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(ramp_trig), .dir(ramp_dir),
        .step_cfg(step_cfg), .len_cfg(len_cfg), .busy(busy), .done(done),
        .load(load), .addr(addr)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam bit IQC = (c < 2);
        tprc_chan #(
            .LUT_W(LUT_W), .DAC_W(DAC_W), .HAS_IQ(IQC)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .tgt_we(tgt_we && (tgt_ch == CH_W'(c))),
            .tgt_data(tgt_data),
            .load(load),
            .lut_word(lut_rd[c*LUT_W +: LUT_W]),
            .en(ch_en[c]),
            .bypass(bypass),
            .iq_mode(iq_mode),
            .iq_data((c == 1) ? iq_q : iq_i),
            .dac(dac_code[c*DAC_W +: DAC_W]),
            .tgt(tgt_vec[c*DAC_W +: DAC_W])
        );
    end

endmodule

// File: rtl/tprc_checker.sv
module tprc_checker #(
    parameter int N_CH  = 3,
    parameter int DAC_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic [N_CH-1:0]       ch_en,
    input logic                  bypass,
    input logic                  iq_mode,
    input logic [DAC_W-1:0]      iq_i,
    input logic [DAC_W-1:0]      iq_q,
    input logic [N_CH*DAC_W-1:0] dac_code,
    input logic [N_CH*DAC_W-1:0] tgt_vec
);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && done) |-> (!busy && $past(busy)));

    assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(busy)) |-> done);

    assert_iq_i_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(iq_mode)) |-> (dac_code[DAC_W-1:0] == $past(iq_i)));

    assert_iq_q_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(iq_mode)) |-> (dac_code[2*DAC_W-1:DAC_W] == $past(iq_q)));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        localparam bit IQC = (c < 2);

        assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(ch_en[c]) && !(IQC && $past(iq_mode)))
            |-> (dac_code[c*DAC_W +: DAC_W] == '0));

        assert_bypass_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(bypass) && $past(ch_en[c]) && !(IQC && $past(iq_mode)))
            |-> (dac_code[c*DAC_W +: DAC_W] == $past(tgt_vec[c*DAC_W +: DAC_W])));
    end

endmodule

bind tx_ramp_ctrl tprc_checker #(
    .N_CH(N_CH), .DAC_W(DAC_W)
) u_tprc_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ch_en(ch_en),
    .bypass(bypass), .iq_mode(iq_mode), .iq_i(iq_i), .iq_q(iq_q),
    .dac_code(dac_code), .tgt_vec(tgt_vec)
);

// File: tb/tb_tx_ramp_ctrl.sv
module tb_tx_ramp_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lut_we = 1'b0;
    logic [1:0]  lut_ch = '0;
    logic [3:0]  lut_addr = '0;
    logic [9:0]  lut_data = '0;
    logic        tgt_we = 1'b0;
    logic [1:0]  tgt_ch = '0;
    logic [11:0] tgt_data = '0;
    logic [7:0]  step_cfg = '0;
    logic [3:0]  len_cfg = '0;
    logic [2:0]  ch_en = '0;
    logic        ramp_dir = 1'b0;
    logic        ramp_trig = 1'b0;
    logic        bypass = 1'b0;
    logic        iq_mode = 1'b0;
    logic [11:0] iq_i = '0;
    logic [11:0] iq_q = '0;
    logic [35:0] dac_code;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tx_ramp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .lut_we(lut_we), .lut_ch(lut_ch),
        .lut_addr(lut_addr), .lut_data(lut_data), .tgt_we(tgt_we),
        .tgt_ch(tgt_ch), .tgt_data(tgt_data), .step_cfg(step_cfg),
        .len_cfg(len_cfg), .ch_en(ch_en), .ramp_dir(ramp_dir),
        .ramp_trig(ramp_trig), .bypass(bypass), .iq_mode(iq_mode),
        .iq_i(iq_i), .iq_q(iq_q), .dac_code(dac_code), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic       dir;
        logic [7:0] step;
        logic [3:0] len;
        logic [2:0] en;
        logic       retrig;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{dir: 1'b1, step: 8'd1, len: 4'd15, en: 3'b111, retrig: 1'b0},
        '{dir: 1'b0, step: 8'd1, len: 4'd15, en: 3'b101, retrig: 1'b0},
        '{dir: 1'b1, step: 8'd3, len: 4'd4,  en: 3'b001, retrig: 1'b1},
        '{dir: 1'b0, step: 8'd0, len: 4'd7,  en: 3'b110, retrig: 1'b0},
        '{dir: 1'b0, step: 8'd2, len: 4'd0,  en: 3'b111, retrig: 1'b0},
        '{dir: 1'b1, step: 8'd5, len: 4'd2,  en: 3'b011, retrig: 1'b1}
    };

    int tg [3] = '{4095, 2048, 1000};

    function automatic int prof(int c, int i);
        return (i * 61 + c * 211 + 17) % 1024;
    endfunction

    function automatic int chan(logic [35:0] v, int c);
        return int'(v[c*12 +: 12]);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        vec_t e;
        int s_sp, n_smp, j, ix, ex;
        string tag;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(dac_code != '0), 0);
        chk("R1", int'(busy), 0);
        chk("R1", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(dac_code != '0), 0);

        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 16; i++) begin
                lut_we = 1'b1; lut_ch = 2'(c); lut_addr = 4'(i); lut_data = 10'(prof(c, i));
                @(negedge clk);
            end
            lut_we = 1'b0;
            tgt_we = 1'b1; tgt_ch = 2'(c); tgt_data = 12'(tg[c]);
            @(negedge clk);
            tgt_we = 1'b0;
        end

        for (int v = 0; v < NV; v++) begin
            e = VECS[v];
            s_sp  = (e.step == 0) ? 1 : int'(e.step);
            n_smp = int'(e.len) + 1;
            ch_en = e.en; ramp_dir = e.dir; step_cfg = e.step; len_cfg = e.len;
            @(negedge clk);
            ramp_trig = 1'b1;
            @(posedge clk);
            @(negedge clk);
            ramp_trig = 1'b0;
            for (int t = 0; t <= n_smp * s_sp + 1; t++) begin
                if (t > 0) @(negedge clk);
                chk("R5", int'(busy), int'(t < n_smp * s_sp));
                chk("R5", int'(done), int'(t == n_smp * s_sp));
                if (t > 0) begin
                    j = (t - 1) / s_sp;
                    if (j > n_smp - 1) j = n_smp - 1;
                    ix = e.dir ? j : n_smp - 1 - j;
                    if (e.retrig)   tag = "R6";
                    else if (e.dir) tag = "R2/R3";
                    else            tag = "R4/R3";
                    for (int c = 0; c < 3; c++) begin
                        if (e.en[c]) begin
                            ex = (prof(c, ix) * tg[c]) >> 10;
                            chk(tag, chan(dac_code, c), ex);
                        end else begin
                            chk("R7", chan(dac_code, c), 0);
                        end
                    end
                end
                if (e.retrig && t == 2) begin
                    ramp_trig = 1'b1; ramp_dir = ~e.dir;
                end
                if (t == 3) ramp_trig = 1'b0;
            end
            repeat (2) @(negedge clk);
        end

        // R8: static target bypass
        ch_en = 3'b111; bypass = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 3; c++) chk("R8", chan(dac_code, c), tg[c]);
        ch_en = 3'b010;
        @(negedge clk);
        chk("R7", chan(dac_code, 0), 0);
        chk("R8", chan(dac_code, 1), tg[1]);

        // R9: I/Q streaming overrides channels 0 and 1 only
        ch_en = 3'b100; iq_mode = 1'b1; iq_i = 12'd2748; iq_q = 12'd291;
        @(negedge clk);
        chk("R9", chan(dac_code, 0), 2748);
        chk("R9", chan(dac_code, 1), 291);
        chk("R9", chan(dac_code, 2), tg[2]);
        iq_i = 12'd4095; iq_q = 12'd0;
        @(negedge clk);
        chk("R9", chan(dac_code, 0), 4095);
        chk("R9", chan(dac_code, 1), 0);

        summary();
        $finish;
    end

endmodule